// File: doc/BRIEF.md
# Receive Checksum Policy Checker

This block sits after the receive parser and checksum engine of an Ethernet MAC. For each parsed frame it gets a one-cycle strobe with a set of flags:

- whether the frame is IP at all, and whether it is IPv6;
- which transport it carries: UDP, UDP-Lite, ICMP or anything else;
- whether an IPv6 fragment extension header is present;
- whether the UDP checksum field holds zero;
- whether the upstream engine found the checksum correct.

From these flags and a small policy register, the block returns one registered verdict, pass or drop, for every strobe.

Ordinary UDP is always held to its checksum. Four policy bits add per-protocol exceptions or checks:

- pass fragmented IPv6 UDP frames without looking at the checksum;
- accept or reject IPv6 UDP frames whose checksum field is zero;
- turn checking on for UDP-Lite;
- turn checking on for ICMP.

Frames that are not IP, and IP transports outside the three named ones, are never dropped by this block. Software loads the policy register through a single write strobe. The frame path needs no handshake: the verdict follows the strobe by exactly one cycle.

Top module: `rx_ckpol_top`

## Requirements
- R1: While reset is high and after it, `dec_valid` and `dec_pass` are 0 and all four policy bits are 0. This holds after a reset asserted in mid-run too, so any previously written policy is cleared.
- R2: A frame strobe (`info_valid`=1) sampled at a clock edge gives `dec_valid`=1 for exactly the following cycle. Back-to-back strobes give back-to-back verdicts. With no strobe, `dec_valid` is 0, and `dec_pass` is 0 whenever `dec_valid` is 0.
- R3: With policy bit 0 (fragment bypass) set, an IPv6 UDP frame with the fragment-header flag passes whatever its checksum flags say. The bypass does not apply to IPv4 UDP.
- R4: With policy bit 0 clear, the fragment-header flag has no effect: the frame gets the verdict of the zero-checksum and checksum-correct rules.
- R5: An IPv6 UDP frame with the zero-checksum flag, and not bypassed by R3, passes when policy bit 1 is set and drops when it is clear. The checksum-correct flag does not matter for such a frame. The zero-checksum flag has no effect on IPv4 UDP.
- R6: UDP-Lite frames (kind code 2) pass unconditionally while policy bit 2 is clear. While it is set, they pass only when the checksum-correct flag is set.
- R7: ICMP frames (kind code 3) pass unconditionally while policy bit 3 is clear. While it is set, they drop when the checksum-correct flag is clear.
- R8: UDP frames (kind code 1) that no exception covers pass exactly when the checksum-correct flag is set.
- R9: A frame with `info_is_ip`=0 always passes, whatever the other flags are. An IP frame of kind code 0 (other transport) always passes.
- R10: `cfg_wr`=1 at an edge loads `cfg_wdata` into the policy register. The new policy governs frames sampled from the next edge on. A frame sampled at the same edge as the write is judged with the previous policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Policy register write strobe |
| cfg_wdata | input | 4 | Policy bits: 0 fragment bypass, 1 zero-checksum accept, 2 UDP-Lite check, 3 ICMP check |
| info_valid | input | 1 | Frame flags are valid this cycle |
| info_kind | input | 2 | Transport: 0 other, 1 UDP, 2 UDP-Lite, 3 ICMP |
| info_is_ip | input | 1 | Frame carries an IP packet |
| info_is_v6 | input | 1 | IP version is 6 |
| info_frag_hdr | input | 1 | IPv6 fragment extension header present |
| info_csum_zero | input | 1 | UDP checksum field equals zero |
| info_csum_ok | input | 1 | Upstream checksum engine found the checksum correct |
| dec_valid | output | 1 | Verdict valid, one cycle after `info_valid` |
| dec_pass | output | 1 | 1 = pass, 0 = drop; only meaningful with `dec_valid` |

## Verification
The assertions assume two things about the inputs:

- every frame flag and the transport code are known (not X) whenever `info_valid` is high;
- reset is held across at least one clock edge before the first frame.

The assertions place no limit on which flag combinations are legal, so they also cover combinations a real parser would never produce, such as a fragment header on IPv4 or a zero-checksum flag on ICMP. The bench keeps within the assumptions by driving every input from a defined value on every cycle. It draws all flag combinations and policy values from a seeded generator, including the nonsensical ones, and writes the policy in the same cycle as a frame at random points.

// File: rtl/rx_ckpol_pkg.sv
package rx_ckpol_pkg;

    localparam int POLICY_W  = 4;
    localparam int KIND_W    = 2;

    typedef enum logic [KIND_W-1:0] {
        L4_OTHER   = 2'd0,
        L4_UDP     = 2'd1,
        L4_UDPLITE = 2'd2,
        L4_ICMP    = 2'd3
    } l4_kind_e;

    // Bit 0 is frag_pass, bit 3 is icmp_check (packed, MSB first)
    typedef struct packed {
        logic icmp_check;
        logic lite_check;
        logic zero_accept;
        logic frag_pass;
    } policy_t;

    typedef struct packed {
        logic     is_ip;
        logic     is_v6;
        logic     frag_hdr;
        logic     csum_zero;
        logic     csum_ok;
        l4_kind_e kind;
    } frame_info_t;

    typedef enum logic [2:0] {
        RSN_UNCHECKED,
        RSN_FRAG_BYPASS,
        RSN_ZERO_ACCEPT,
        RSN_ZERO_REJECT,
        RSN_SUM_GOOD,
        RSN_SUM_BAD
    } reason_e;

    typedef struct packed {
        logic valid;
        logic pass;
    } verdict_t;

    function automatic logic reason_passes(reason_e r);
        return (r != RSN_ZERO_REJECT) && (r != RSN_SUM_BAD);
    endfunction

    function automatic reason_e sum_reason(logic ok);
        return ok ? RSN_SUM_GOOD : RSN_SUM_BAD;
    endfunction

endpackage

// File: rtl/rx_ckpol_cfg.sv
module rx_ckpol_cfg
    import rx_ckpol_pkg::*;
#(
    parameter logic [POLICY_W-1:0] RESET_VAL = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [POLICY_W-1:0] wdata,
    output policy_t             pol
);

    logic [POLICY_W-1:0] pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= RESET_VAL;
        end else if (wr) begin
            pol_q <= wdata;
        end
    end

    assign pol = policy_t'(pol_q);

endmodule

// File: rtl/rx_ckpol_rules.sv
module rx_ckpol_rules
    import rx_ckpol_pkg::*;
(
    input  frame_info_t info,
    input  policy_t     pol,
    output logic        pass
);

    logic    v6_udp;
    reason_e reason;

    always_comb begin
        v6_udp = info.is_ip && info.is_v6 && (info.kind == L4_UDP);
        reason = RSN_UNCHECKED;
        if (info.is_ip) begin
            case (info.kind)
                L4_UDP: begin
                    if (v6_udp && pol.frag_pass && info.frag_hdr) begin
                        reason = RSN_FRAG_BYPASS;
                    end else if (v6_udp && info.csum_zero) begin
                        reason = pol.zero_accept ? RSN_ZERO_ACCEPT : RSN_ZERO_REJECT;
                    end else begin
                        reason = sum_reason(info.csum_ok);
                    end
                end
                L4_UDPLITE: begin
                    if (pol.lite_check) begin
                        reason = sum_reason(info.csum_ok);
                    end
                end
                L4_ICMP: begin
                    if (pol.icmp_check) begin
                        reason = sum_reason(info.csum_ok);
                    end
                end
                default: reason = RSN_UNCHECKED;
            endcase
        end
        pass = reason_passes(reason);
    end

endmodule

// File: rtl/rx_ckpol_top.sv
module rx_ckpol_top
    import rx_ckpol_pkg::*;
#(
    parameter logic [POLICY_W-1:0] POLICY_RESET = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [POLICY_W-1:0] cfg_wdata,
    input  logic                info_valid,
    input  logic [KIND_W-1:0]   info_kind,
    input  logic                info_is_ip,
    input  logic                info_is_v6,
    input  logic                info_frag_hdr,
    input  logic                info_csum_zero,
    input  logic                info_csum_ok,
    output logic                dec_valid,
    output logic                dec_pass
);

    policy_t     pol;
    frame_info_t info;
    logic        rule_pass;
    verdict_t    verdict_q;

    rx_ckpol_cfg #(
        .RESET_VAL (POLICY_RESET)
    ) i_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .pol   (pol)
    );

    always_comb begin
        info.is_ip     = info_is_ip;
        info.is_v6     = info_is_v6;
        info.frag_hdr  = info_frag_hdr;
        info.csum_zero = info_csum_zero;
        info.csum_ok   = info_csum_ok;
        info.kind      = l4_kind_e'(info_kind);
    end

    rx_ckpol_rules i_rules (
        .info (info),
        .pol  (pol),
        .pass (rule_pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q.valid <= info_valid;
            verdict_q.pass  <= info_valid && rule_pass;
        end
    end

    assign dec_valid = verdict_q.valid;
    assign dec_pass  = verdict_q.pass;

    // R2
    verdict_follows_chk: assert property (@(posedge clk) disable iff (rst)
        info_valid |=> dec_valid);

    // R2
    no_spurious_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        !info_valid |=> !dec_valid);

    // R2
    idle_pass_low_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !dec_pass);

    // R9
    non_ip_passes_chk: assert property (@(posedge clk) disable iff (rst)
        (info_valid && !info_is_ip) |=> dec_pass);

    // R3
    frag_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (info_valid && info_is_ip && info_is_v6 && info_kind == 2'd1
         && info_frag_hdr && pol.frag_pass) |=> dec_pass);

    // R5
    zero_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (info_valid && info_is_ip && info_is_v6 && info_kind == 2'd1
         && info_csum_zero && !info_frag_hdr && !pol.zero_accept) |=> !dec_pass);

    // R7
    icmp_bad_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (info_valid && info_is_ip && info_kind == 2'd3
         && pol.icmp_check && !info_csum_ok) |=> !dec_pass);

    // R8
    v4_udp_bad_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (info_valid && info_is_ip && !info_is_v6 && info_kind == 2'd1
         && !info_csum_ok) |=> !dec_pass);

endmodule

// File: tb/test_rx_ckpol_top.sv
`timescale 1ns/1ps
module test_rx_ckpol_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr;
    logic [3:0] cfg_wdata;
    logic       info_valid;
    logic [1:0] info_kind;
    logic       info_is_ip, info_is_v6, info_frag_hdr, info_csum_zero, info_csum_ok;
    logic       dec_valid, dec_pass;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [3:0] model_cfg;

    always #5 clk = ~clk;

    rx_ckpol_top i_rx_ckpol_top (
        .clk            (clk),
        .rst            (rst),
        .cfg_wr         (cfg_wr),
        .cfg_wdata      (cfg_wdata),
        .info_valid     (info_valid),
        .info_kind      (info_kind),
        .info_is_ip     (info_is_ip),
        .info_is_v6     (info_is_v6),
        .info_frag_hdr  (info_frag_hdr),
        .info_csum_zero (info_csum_zero),
        .info_csum_ok   (info_csum_ok),
        .dec_valid      (dec_valid),
        .dec_pass       (dec_pass)
    );

    function automatic bit model_pass(bit ip, bit v6, bit frag, bit zero, bit ok,
                                      logic [1:0] kind, logic [3:0] c);
        if (!ip) return 1'b1;
        case (kind)
            2'd1: begin
                if (v6 && c[0] && frag) return 1'b1;
                if (v6 && zero)         return c[1];
                return ok;
            end
            2'd2:    return c[2] ? ok : 1'b1;
            2'd3:    return c[3] ? ok : 1'b1;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(bit actual, bit expected, string req);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, actual, expected);
        end
    endtask

    task automatic drive(bit ip, bit v6, bit frag, bit zero, bit ok, logic [1:0] kind);
        info_valid     = 1'b1;
        info_is_ip     = ip;
        info_is_v6     = v6;
        info_frag_hdr  = frag;
        info_csum_zero = zero;
        info_csum_ok   = ok;
        info_kind      = kind;
    endtask

    // one frame: drive at negedge, verdict checked at the next negedge
    task automatic send(bit ip, bit v6, bit frag, bit zero, bit ok, logic [1:0] kind,
                        bit exp, string req);
        @(negedge clk);
        drive(ip, v6, frag, zero, ok, kind);
        @(negedge clk);
        info_valid = 1'b0;
        check(dec_valid, 1'b1, "R2 verdict valid");
        check(dec_pass, exp, req);
        check(model_pass(ip, v6, frag, zero, ok, kind, model_cfg), exp, {req, " model"});
    endtask

    task automatic write_cfg(logic [3:0] v);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
        model_cfg = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0; info_valid = 1'b0;
        info_kind = '0; info_is_ip = 0; info_is_v6 = 0; info_frag_hdr = 0;
        info_csum_zero = 0; info_csum_ok = 0;
        model_cfg = '0;
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        check(dec_valid, 1'b0, "R1 dec_valid in reset");
        check(dec_pass, 1'b0, "R1 dec_pass in reset");
        rst = 1'b0;

        // R1 default policy: all exceptions off
        send(1, 1, 1, 0, 0, 2'd1, 1'b0, "R1 R4 default frag no bypass");
        send(1, 0, 0, 0, 0, 2'd3, 1'b1, "R1 R7 default icmp unchecked");
        send(1, 0, 0, 0, 0, 2'd2, 1'b1, "R1 R6 default lite unchecked");
        send(1, 1, 0, 1, 1, 2'd1, 1'b0, "R1 R5 default zero rejected");
        // R2 idle cycle
        @(negedge clk);
        check(dec_valid, 1'b0, "R2 idle no verdict");
        check(dec_pass, 1'b0, "R2 idle pass low");

        write_cfg(4'b0001);
        send(1, 1, 1, 0, 0, 2'd1, 1'b1, "R3 v6 frag bypass");
        send(1, 1, 1, 1, 0, 2'd1, 1'b1, "R3 bypass over zero");
        send(1, 0, 1, 0, 0, 2'd1, 1'b0, "R3 no bypass on v4");
        send(1, 1, 0, 0, 0, 2'd1, 1'b0, "R8 v6 udp bad");
        send(1, 1, 0, 0, 1, 2'd1, 1'b1, "R8 v6 udp good");

        write_cfg(4'b0010);
        send(1, 1, 0, 1, 0, 2'd1, 1'b1, "R5 zero accepted");
        send(1, 1, 1, 1, 0, 2'd1, 1'b1, "R4 frag ignored zero rule");
        send(1, 1, 1, 0, 0, 2'd1, 1'b0, "R4 frag ignored bad sum");
        send(1, 0, 0, 1, 0, 2'd1, 1'b0, "R5 zero no effect on v4");

        write_cfg(4'b0100);
        send(1, 0, 0, 0, 0, 2'd2, 1'b0, "R6 lite bad dropped");
        send(1, 1, 0, 0, 1, 2'd2, 1'b1, "R6 lite good passes");

        write_cfg(4'b1000);
        send(1, 0, 0, 0, 0, 2'd3, 1'b0, "R7 icmp bad dropped");
        send(1, 1, 0, 0, 1, 2'd3, 1'b1, "R7 icmp good passes");

        send(0, 1, 0, 1, 0, 2'd1, 1'b1, "R9 non-ip passes");
        send(1, 0, 0, 0, 0, 2'd0, 1'b1, "R9 other transport passes");

        // R10 write in the same cycle as a frame uses the old policy
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 4'b0000;
        drive(1, 0, 0, 0, 0, 2'd3);
        @(negedge clk);
        cfg_wr = 1'b0; info_valid = 1'b0;
        check(dec_pass, 1'b0, "R10 same-edge write uses old policy");
        model_cfg = 4'b0000;
        send(1, 0, 0, 0, 0, 2'd3, 1'b1, "R10 new policy next frame");

        // R1 mid-run reset clears the policy
        write_cfg(4'b1111);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; model_cfg = 4'b0000;
        check(dec_valid, 1'b0, "R1 mid-run reset valid");
        send(1, 0, 0, 0, 0, 2'd3, 1'b1, "R1 policy cleared by reset");

        // random back-to-back frames with occasional same-edge writes
        begin
            bit exp_prev = 0;
            bit have_prev = 0;
            for (int i = 0; i < 3000; i++) begin
                bit ip, v6, fr, zr, ok, vld;
                logic [1:0] kd;
                @(negedge clk);
                if (have_prev) begin
                    check(dec_valid, 1'b1, "R2 random valid");
                    check(dec_pass, exp_prev, "R3-R9 random verdict");
                end else begin
                    check(dec_valid, 1'b0, "R2 random idle");
                end
                ip = ($urandom % 8) != 0;
                v6 = $urandom % 2; fr = $urandom % 2; zr = $urandom % 2; ok = $urandom % 2;
                kd = 2'($urandom % 4);
                vld = ($urandom % 5) != 0;
                if (vld) begin
                    drive(ip, v6, fr, zr, ok, kd);
                    exp_prev = model_pass(ip, v6, fr, zr, ok, kd, model_cfg);
                end else begin
                    info_valid = 1'b0;
                end
                have_prev = vld;
                if (($urandom % 8) == 0) begin
                    cfg_wr    = 1'b1;
                    cfg_wdata = 4'($urandom % 16);
                    model_cfg = cfg_wdata; // R10 applies from the following frame
                end else begin
                    cfg_wr = 1'b0;
                end
            end
            @(negedge clk);
            info_valid = 1'b0; cfg_wr = 1'b0;
            if (have_prev) check(dec_pass, exp_prev, "R3-R9 random last");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule